// File: doc/BRIEF.md
# PCIe Configuration Window Translator

This block sits between a CPU-side access port and the slave address bus of a PCIe core. A 64 KiB window is mapped somewhere in the CPU address space. A read or write that lands inside the window is rebuilt as a configuration-cycle address. The block also classifies the cycle as type 0 or type 1. An access outside the window produces no cycle at all.

The target bus, device and function are not taken from the access address. They come from one of two 16-bit selector registers. Bit 12 of the offset into the window picks which of the two is used. The offset bits 15:12 decide the cycle type. The offset bits 11:2 become the register number. Software programs the window base and the packed selector word through a small register port and can read both back.

The request is presented one clock after the access is sampled. Register writes take effect from the following cycle onward.

Top module: `cfg_window_xlate`

## Requirements
- R1: While reset is held and right after it, both registers read back as zero and every request output is low (hit, read, write, type1, address and byte enables all zero).
- R2: An access hits when read or write is strobed and base <= address < base + 65536, compared on the full 32-bit address. The base need not be aligned. A window reaching past 0xFFFF_FFFF does not wrap to address zero.
- R3: Without a hit, the request outputs are all zero: no read, no write, no type1, a zero address and zero byte enables.
- R4: The outgoing address bits [31:16] take the selector register picked by window offset bit 12. Offset bit 12 at 0 picks selector 0 and offset bit 12 at 1 picks selector 1. Bus number is in [31:24], device in [23:19] and function in [18:16].
- R5: The outgoing address bits [15:12] and [1:0] are zero. Bits [11:2] equal offset bits [11:2].
- R6: The type1 flag is set exactly when window offset bits [15:12] are nonzero. As a result, the first 4 KiB of the window only produces type 0 cycles, always with selector 0.
- R7: On a hit the byte enables are passed through unchanged.
- R8: Register address 0 holds the 32-bit window base. Register address 1 holds the selector word: selector 0 in bits [15:0] and selector 1 in bits [31:16]. The read data shows the register currently addressed.
- R9: The request outputs appear one clock after the access is sampled. An access sampled on the same edge as a register write uses the old register value. Later accesses use the new value.
- R10: On a hit, the read and write strobes are passed through as given. An access inside the window with neither strobe raises no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 window base, 1 selector word |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read-back of the selected register |
| acc_rd_i | input | 1 | CPU read strobe |
| acc_wr_i | input | 1 | CPU write strobe |
| acc_addr_i | input | 32 | CPU byte address |
| acc_be_i | input | 4 | CPU byte enables |
| cfg_hit_o | output | 1 | Access fell in the window and a cycle is issued |
| cfg_rd_o | output | 1 | Configuration read strobe |
| cfg_wr_o | output | 1 | Configuration write strobe |
| cfg_type1_o | output | 1 | 1 for a type 1 cycle, 0 for type 0 |
| cfg_addr_o | output | 32 | Configuration-cycle address for the core slave bus |
| cfg_be_o | output | 4 | Byte enables of the cycle |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 64 KiB window split into 4 KiB regions, and two 16-bit selectors. With these values the bench can reach both window edges, for an aligned base, for an odd byte-granular base, and for a base so close to the top of the address space that the window would wrap. Region 0, region 1 and higher regions are all hit, which exercises both selectors and both cycle types. An exact cycle in which a selector write and an access coincide is also covered.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    localparam int ADDR_W   = 32;
    localparam int WIN_W    = 16;
    localparam int REGION_W = 12;
    localparam int SEL_W    = 16;
    localparam int NUM_SEL  = 2;
    localparam int BE_W     = 4;

    typedef enum logic [0:0] {
        RSEL_BASE = 1'b0,
        RSEL_SEL  = 1'b1
    } reg_slot_e;

    typedef struct packed {
        logic              hit;
        logic              rd;
        logic              wr;
        logic              type1;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
    } cfg_req_t;
endpackage

// File: rtl/cfgx_regs.sv
module cfgx_regs
    import cfgx_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int SW      = SEL_W,
    parameter int NSEL    = NUM_SEL
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 we_i,
    input  logic                 addr_i,
    input  logic [AW-1:0]        wdata_i,
    output logic [AW-1:0]        rdata_o,
    output logic [AW-1:0]        base_o,
    output logic [NSEL*SW-1:0]   sel_word_o
);
    localparam int WORD_W = NSEL * SW;

    typedef struct packed {
        logic [AW-1:0]     base;
        logic [WORD_W-1:0] sel_word;
    } regs_t;

    regs_t     regs_d, regs_q;
    reg_slot_e slot;

    assign slot = reg_slot_e'(addr_i);

    always_comb begin
        regs_d = regs_q;
        if (we_i) begin
            unique case (slot)
                RSEL_BASE: regs_d.base     = wdata_i;
                RSEL_SEL:  regs_d.sel_word = wdata_i[WORD_W-1:0];
                default:   regs_d          = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        unique case (slot)
            RSEL_BASE: rdata_o = regs_q.base;
            RSEL_SEL:  rdata_o = AW'(regs_q.sel_word);
            default:   rdata_o = '0;
        endcase
    end

    assign base_o     = regs_q.base;
    assign sel_word_o = regs_q.sel_word;
endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int WW    = WIN_W,
    parameter int RW    = REGION_W,
    parameter int SW    = SEL_W,
    parameter int NSEL  = NUM_SEL
) (
    input  logic [AW-1:0]      addr_i,
    input  logic [AW-1:0]      base_i,
    input  logic [NSEL*SW-1:0] sel_word_i,
    output logic               in_win_o,
    output logic               type1_o,
    output logic [AW-1:0]      cfg_addr_o
);
    localparam int IDX_W  = (NSEL > 1) ? $clog2(NSEL) : 1;
    localparam int GAP_W  = WW - RW;
    localparam int REGN_W = RW - 2;

    logic [AW-1:0]    offset;
    logic [SW-1:0]    sel_arr [NSEL];
    logic [IDX_W-1:0] idx;
    logic [SW-1:0]    sel_pick;
    logic             unused_low;

    genvar g;
    generate
        for (g = 0; g < NSEL; g++) begin : g_sel
            assign sel_arr[g] = sel_word_i[g*SW +: SW];
        end
    endgenerate

    assign offset     = addr_i - base_i;
    assign in_win_o   = (addr_i >= base_i) && (offset[AW-1:WW] == '0);
    assign type1_o    = |offset[WW-1:RW];
    assign idx        = offset[RW +: IDX_W];
    assign sel_pick   = sel_arr[idx];
    assign cfg_addr_o = {sel_pick, {GAP_W{1'b0}}, offset[RW-1:2], 2'b00};
    assign unused_low = ^offset[1:0];
endmodule

// File: rtl/cfg_window_xlate.sv
module cfg_window_xlate
    import cfgx_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int WW   = WIN_W,
    parameter int RW   = REGION_W,
    parameter int SW   = SEL_W,
    parameter int NSEL = NUM_SEL,
    parameter int BW   = BE_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          reg_we_i,
    input  logic          reg_addr_i,
    input  logic [AW-1:0] reg_wdata_i,
    output logic [AW-1:0] reg_rdata_o,
    input  logic          acc_rd_i,
    input  logic          acc_wr_i,
    input  logic [AW-1:0] acc_addr_i,
    input  logic [BW-1:0] acc_be_i,
    output logic          cfg_hit_o,
    output logic          cfg_rd_o,
    output logic          cfg_wr_o,
    output logic          cfg_type1_o,
    output logic [AW-1:0] cfg_addr_o,
    output logic [BW-1:0] cfg_be_o
);
    logic [AW-1:0]      base_q;
    logic [NSEL*SW-1:0] sel_word_q;
    logic               in_win;
    logic               is_type1;
    logic [AW-1:0]      xl_addr;

    typedef struct packed {
        logic          hit;
        logic          rd;
        logic          wr;
        logic          type1;
        logic [AW-1:0] addr;
        logic [BW-1:0] be;
    } req_t;

    req_t req_d, req_q;

    cfgx_regs #(.AW(AW), .SW(SW), .NSEL(NSEL)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (reg_we_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .base_o     (base_q),
        .sel_word_o (sel_word_q)
    );

    cfgx_decode #(.AW(AW), .WW(WW), .RW(RW), .SW(SW), .NSEL(NSEL)) u_dec (
        .addr_i     (acc_addr_i),
        .base_i     (base_q),
        .sel_word_i (sel_word_q),
        .in_win_o   (in_win),
        .type1_o    (is_type1),
        .cfg_addr_o (xl_addr)
    );

    always_comb begin
        req_d = '0;
        if (in_win && (acc_rd_i || acc_wr_i)) begin
            req_d.hit   = 1'b1;
            req_d.rd    = acc_rd_i;
            req_d.wr    = acc_wr_i;
            req_d.type1 = is_type1;
            req_d.addr  = xl_addr;
            req_d.be    = acc_be_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign cfg_hit_o   = req_q.hit;
    assign cfg_rd_o    = req_q.rd;
    assign cfg_wr_o    = req_q.wr;
    assign cfg_type1_o = req_q.type1;
    assign cfg_addr_o  = req_q.addr;
    assign cfg_be_o    = req_q.be;
endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker #(
    parameter int AW   = 32,
    parameter int SW   = 16,
    parameter int NSEL = 2,
    parameter int BW   = 4
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               acc_rd_i,
    input logic               acc_wr_i,
    input logic [BW-1:0]      acc_be_i,
    input logic [NSEL*SW-1:0] sel_word_q,
    input logic               cfg_hit_o,
    input logic               cfg_rd_o,
    input logic               cfg_wr_o,
    input logic               cfg_type1_o,
    input logic [AW-1:0]      cfg_addr_o,
    input logic [BW-1:0]      cfg_be_o
);
    assert_no_strobe_no_hit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!acc_rd_i && !acc_wr_i) |=> !cfg_hit_o);

    assert_miss_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_hit_o |-> (!cfg_rd_o && !cfg_wr_o && !cfg_type1_o
                        && cfg_addr_o == '0 && cfg_be_o == '0));

    assert_gap_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_hit_o |-> (cfg_addr_o[15:12] == 4'h0 && cfg_addr_o[1:0] == 2'b00));

    assert_type0_sel0_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_hit_o && !cfg_type1_o) |-> (cfg_addr_o[AW-1:AW-SW] == $past(sel_word_q[SW-1:0])));

    assert_be_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_hit_o |-> (cfg_be_o == $past(acc_be_i)));

    assert_strobe_pass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_hit_o |-> (cfg_rd_o == $past(acc_rd_i) && cfg_wr_o == $past(acc_wr_i)
                       && (cfg_rd_o || cfg_wr_o)));
endmodule

bind cfg_window_xlate cfgx_checker #(.AW(AW), .SW(SW), .NSEL(NSEL), .BW(BW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_rd_i    (acc_rd_i),
    .acc_wr_i    (acc_wr_i),
    .acc_be_i    (acc_be_i),
    .sel_word_q  (sel_word_q),
    .cfg_hit_o   (cfg_hit_o),
    .cfg_rd_o    (cfg_rd_o),
    .cfg_wr_o    (cfg_wr_o),
    .cfg_type1_o (cfg_type1_o),
    .cfg_addr_o  (cfg_addr_o),
    .cfg_be_o    (cfg_be_o)
);

// File: tb/tb_cfg_window_xlate.sv
`timescale 1ns/1ps
module tb_cfg_window_xlate;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        reg_we_i = 1'b0;
    logic        reg_addr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        acc_rd_i = 1'b0;
    logic        acc_wr_i = 1'b0;
    logic [31:0] acc_addr_i = '0;
    logic [3:0]  acc_be_i = '0;
    logic        cfg_hit_o, cfg_rd_o, cfg_wr_o, cfg_type1_o;
    logic [31:0] cfg_addr_o;
    logic [3:0]  cfg_be_o;

    always #2.5 clk_i = ~clk_i;

    cfg_window_xlate dut (.*);

    typedef struct packed {
        logic        hit;
        logic        rd;
        logic        wr;
        logic        type1;
        logic [31:0] addr;
        logic [3:0]  be;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];
    int    n_chk = 0;
    int    n_bad = 0;
    logic [31:0] m_base = '0;
    logic [31:0] m_sel  = '0;

    function automatic exp_t predict(logic rd, logic wr, logic [31:0] a, logic [3:0] be);
        exp_t e = '0;
        logic [31:0] off = a - m_base;
        if (a >= m_base && off[31:16] == 16'h0 && (rd || wr)) begin
            e.hit   = 1'b1;
            e.rd    = rd;
            e.wr    = wr;
            e.type1 = (off[15:12] != 4'h0);
            e.addr  = {(off[12] ? m_sel[31:16] : m_sel[15:0]), 4'h0, off[11:2], 2'b00};
            e.be    = be;
        end
        return e;
    endfunction

    // one clock of stimulus: optional register write plus optional access
    task automatic cycle(input logic we, input logic ra, input logic [31:0] wd,
                         input logic rd, input logic wr, input logic [31:0] a,
                         input logic [3:0] be, input string tag);
        @(negedge clk_i);
        reg_we_i = we; reg_addr_i = ra; reg_wdata_i = wd;
        acc_rd_i = rd; acc_wr_i = wr; acc_addr_i = a; acc_be_i = be;
        exp_q.push_back(predict(rd, wr, a, be));
        tag_q.push_back(tag);
        if (we) begin
            if (ra) m_sel = wd; else m_base = wd;
        end
    endtask

    task automatic access(input logic rd, input logic wr, input logic [31:0] a,
                          input logic [3:0] be, input string tag);
        cycle(1'b0, 1'b0, 32'h0, rd, wr, a, be, tag);
    endtask

    task automatic regwrite(input logic ra, input logic [31:0] wd);
        cycle(1'b1, ra, wd, 1'b0, 1'b0, 32'h0, 4'h0, "R8 idle during write");
    endtask

    task automatic readback(input logic ra, input logic [31:0] expv, input string tag);
        cycle(1'b0, ra, 32'h0, 1'b0, 1'b0, 32'h0, 4'h0, tag);
        #1;
        n_chk++;
        if (reg_rdata_o !== expv) begin
            n_bad++;
            $display("FAIL %s: readback actual %h expected %h", tag, reg_rdata_o, expv);
        end
    endtask

    // monitor: compares each registered request against the scoreboard
    initial begin
        forever begin
            @(posedge clk_i);
            #1;
            if (exp_q.size() > 0) begin
                exp_t  e = exp_q.pop_front();
                string t = tag_q.pop_front();
                exp_t  got = {cfg_hit_o, cfg_rd_o, cfg_wr_o, cfg_type1_o, cfg_addr_o, cfg_be_o};
                n_chk++;
                if (got !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual hit=%b rd=%b wr=%b t1=%b addr=%h be=%h expected hit=%b rd=%b wr=%b t1=%b addr=%h be=%h",
                             t, got.hit, got.rd, got.wr, got.type1, got.addr, got.be,
                             e.hit, e.rd, e.wr, e.type1, e.addr, e.be);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: state during reset
        acc_rd_i = 1'b1; acc_addr_i = 32'h10; acc_be_i = 4'hF;
        repeat (3) @(negedge clk_i);
        n_chk++;
        if ({cfg_hit_o, cfg_rd_o, cfg_wr_o, cfg_type1_o, cfg_addr_o, cfg_be_o} !== '0) begin
            n_bad++;
            $display("FAIL R1: outputs in reset actual %b%b%b%b %h %h expected all zero",
                     cfg_hit_o, cfg_rd_o, cfg_wr_o, cfg_type1_o, cfg_addr_o, cfg_be_o);
        end
        reg_addr_i = 1'b1; #1;
        n_chk++;
        if (reg_rdata_o !== 32'h0) begin
            n_bad++;
            $display("FAIL R1: selector word in reset actual %h expected 0", reg_rdata_o);
        end
        acc_rd_i = 1'b0; acc_addr_i = '0; acc_be_i = '0;
        @(negedge clk_i);
        rst_ni = 1'b1;

        access(1'b0, 1'b0, 32'h0, 4'h0, "R1 idle after reset");
        readback(1'b0, 32'h0, "R1 base after reset");
        access(1'b1, 1'b0, 32'h0000_0010, 4'hF, "R2 zero base hit");

        regwrite(1'b0, 32'h2001_0000);
        regwrite(1'b1, 32'hABCD_1234);
        readback(1'b0, 32'h2001_0000, "R8 base readback");
        readback(1'b1, 32'hABCD_1234, "R8 selector readback");

        access(1'b1, 1'b0, 32'h2001_0084, 4'b0011, "R4 R7 region0 sel0");
        access(1'b0, 1'b1, 32'h2001_1FFC, 4'hF,    "R4 R6 region1 sel1");
        access(1'b1, 1'b0, 32'h2001_2A47, 4'b0100, "R5 R6 region2 drop low bits");
        access(1'b0, 1'b1, 32'h2001_F000, 4'b1000, "R6 region15");
        access(1'b1, 1'b0, 32'h2001_0000, 4'hF,    "R2 lower edge");
        access(1'b1, 1'b0, 32'h2001_FFFF, 4'hF,    "R2 upper edge");
        access(1'b1, 1'b0, 32'h2000_FFFC, 4'hF,    "R2 R3 below window");
        access(1'b0, 1'b1, 32'h2002_0000, 4'hF,    "R2 R3 above window");
        access(1'b0, 1'b0, 32'h2001_0040, 4'hF,    "R10 no strobe");
        access(1'b1, 1'b1, 32'h2001_1008, 4'b0110, "R10 both strobes");

        cycle(1'b1, 1'b1, 32'h1111_2222, 1'b1, 1'b0, 32'h2001_0100, 4'hF, "R9 same-edge write uses old");
        access(1'b1, 1'b0, 32'h2001_0100, 4'hF, "R9 next access uses new");
        readback(1'b1, 32'h1111_2222, "R8 R9 updated selector");

        regwrite(1'b0, 32'h0000_8123);
        access(1'b1, 1'b0, 32'h0000_8123, 4'hF, "R2 R6 unaligned base start");
        access(1'b1, 1'b0, 32'h0000_9123, 4'hF, "R4 R6 unaligned base region1");
        access(1'b1, 1'b0, 32'h0000_8122, 4'hF, "R2 unaligned below");
        access(1'b0, 1'b1, 32'h0001_8122, 4'hF, "R2 unaligned last byte");
        access(1'b0, 1'b1, 32'h0001_8123, 4'hF, "R2 unaligned past end");

        regwrite(1'b0, 32'hFFFF_8000);
        access(1'b1, 1'b0, 32'hFFFF_FFFC, 4'hF, "R2 R4 top of address space");
        access(1'b1, 1'b0, 32'h0000_0004, 4'hF, "R2 no wrap");
        access(1'b0, 1'b0, 32'h0, 4'h0, "R3 drain");

        @(negedge clk_i);
        @(negedge clk_i);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule